// File: doc/BRIEF.md
# Zero-Suppressed Hit Readout Serializer

After an acquisition window this block empties the hit store of a 64-channel front-end chip onto one shared serial data line. Several such chips share the line and pass a readout token from one to the next around a ring. Each chip transmits only while it holds the token. When a chip's `readStart` pulse arrives, the block sends a stream of 16-bit words, most significant bit first, and then raises `tokenOut` so that the next chip in the ring can begin.

Zero suppression keeps the stream short. Channels without hits contribute no words at all. The stream always has the same order:

1. One identity word carrying the 7-bit chip number.
2. One summary word for each channel that has hits, giving its channel number and how many events it stored.
3. One event word for every stored event, carrying the 12-bit bunch-crossing stamp and the 2-bit threshold code.

Every word ends in an even-parity bit. The per-channel event store is outside the block. The block reads it through a combinational address/data port, and takes the per-channel event counts as a flat vector.

A mode input decides what a chip with no hits does. It can send only its identity word, or it can stay silent and hand the token on at once.

Top module: `rdo_serializer`

## Requirements
- R1: On an accepted `readStart`, the first word sent is the identity word. Its layout is: bits [15:14]=2'b11, bits [13:8]=0, bits [7:1]=`chipId`, bit 0=parity. The first bit appears on `serOut`, with `serValid` high, in the cycle after `readStart` is sampled.
- R2: Words are shifted out MSB first. Each word occupies 16 consecutive cycles with `serValid` high. The stream has no idle cycles between words, from the first bit to the last.
- R3: Summary words follow the identity word, one per channel whose event count is nonzero, in descending channel order (63 down to 0). Their layout is: [15:14]=2'b10, [13:8]=channel, [7:4]=event count, [3:1]=0, bit 0=parity. Channels with a count of zero produce no word.
- R4: Event words follow all summary words. They are grouped by channel in the same descending order, and within a channel they run over slots 0 up to count−1. Their layout is: bit 15=0, [14:3]=stamp, [2:1]=code, bit 0=parity. In the stored event, `memData` [13:2] holds the stamp and [1:0] holds the code. The slot being read is presented on `memChan`/`memSlot`.
- R5: Bit 0 of every word makes the 16-bit word even parity, that is, bit 0 is the XOR of bits 15..1.
- R6: An event count above 8 is treated as 8, both in the summary word and in the number of event words sent.
- R7: With all counts zero and `alwaysSendId`=0, `serValid` stays low and `tokenOut` is high in the cycle after `readStart` is sampled.
- R8: With all counts zero and `alwaysSendId`=1, only the identity word is sent, followed by the token.
- R9: `tokenOut` is high for exactly one cycle per readout, in the cycle right after the last serial bit. It is never high together with `serValid`.
- R10: `readStart` has no effect while a readout is in progress, including during the last-bit cycle and the token cycle. The stream and the single token pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| readStart | input | 1 | Incoming token; one-cycle pulse that starts a readout |
| chipId | input | 7 | Chip number placed in the identity word |
| alwaysSendId | input | 1 | 1: an empty chip still sends its identity word |
| evtCount | input | 256 | Per-channel event counts, 4 bits each, channel n at [4n+3:4n] |
| memChan | output | 6 | Channel of the event the block is about to load |
| memSlot | output | 3 | Slot of the event the block is about to load |
| memData | input | 14 | Stored event at memChan/memSlot: stamp [13:2], code [1:0] |
| serOut | output | 1 | Serial data, MSB of each word first |
| serValid | output | 1 | High while serOut carries a stream bit |
| tokenOut | output | 1 | One-cycle pulse passing the token to the next chip |

## Verification
Two pairs of events can fall in the same clock cycle, and the bench provokes both.

The first pair is a word boundary and a change of phase. On the edge where the last bit of one word leaves, the next word must load. At the boundaries from identity to summary and from summary to event, that next word also comes from a different source. The bench judges this by requiring the stream to be gap-free, with exactly 16 valid cycles per expected word.

The second pair is a fresh `readStart` that arrives while the readout is still busy. The bench pulses it mid-stream, on the exact cycle of the final bit, and on the token cycle. It then requires the stream to be identical to the expected one, with exactly one token pulse and no bits after it.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int NUM_CH  = 64;
  localparam int MAX_EVT = 8;
  localparam int CNT_W   = 4;
  localparam int ID_W    = 7;
  localparam int BCID_W  = 12;
  localparam int ENC_W   = 2;
  localparam int EVT_W   = BCID_W + ENC_W;
  localparam int WORD_W  = 16;

  typedef enum logic [1:0] {
    W_ID  = 2'd0,
    W_GEN = 2'd1,
    W_EVT = 2'd2
  } wordKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;
    wordKind_t kind;
  } dpCtrl_t;

  function automatic logic [WORD_W-1:0] addParity(input logic [WORD_W-1:0] raw);
    return {raw[WORD_W-1:1], ^raw[WORD_W-1:1]};
  endfunction
endpackage

// File: rtl/rdo_ctrl.sv
module rdo_ctrl
  import rdo_pkg::*;
#(
  parameter int NCH  = NUM_CH,
  parameter int NEVT = MAX_EVT,
  parameter int CW   = CNT_W,
  localparam int CH_W   = $clog2(NCH),
  localparam int SLOT_W = $clog2(NEVT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readStart,
  input  logic              alwaysSendId,
  input  logic [NCH*CW-1:0] evtCount,
  input  logic              wordEnd,
  output dpCtrl_t           dpc,
  output logic [CH_W-1:0]   ldChan,
  output logic [SLOT_W-1:0] ldSlot,
  output logic [CW-1:0]     ldCnt,
  output logic              tokenOut
);
  localparam logic [CW-1:0] MAX_CNT = CW'(NEVT);

  typedef enum logic [2:0] {S_IDLE, S_ID, S_GEN, S_EVT, S_TOK} state_t;

  state_t            state, nState;
  logic [CH_W-1:0]   curChan, nChan;
  logic [SLOT_W-1:0] curSlot, nSlot;
  logic [CW-1:0]     clCnt [NCH];
  logic [NCH-1:0]    hitVec;
  logic [CH_W-1:0]   firstHit, nextHit;
  logic              anyHit, nextAny, slotMore;

  // per-channel count clamp and hit flag
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CW-1:0] rawCnt;
    assign rawCnt     = evtCount[ch*CW +: CW];
    assign clCnt[ch]  = (rawCnt > MAX_CNT) ? MAX_CNT : rawCnt;
    assign hitVec[ch] = (rawCnt != '0);
  end

  // highest hit channel overall, and highest below the current one
  always_comb begin
    firstHit = '0;
    anyHit   = 1'b0;
    nextHit  = '0;
    nextAny  = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (hitVec[i]) begin
        firstHit = CH_W'(i);
        anyHit   = 1'b1;
        if (i < int'(curChan)) begin
          nextHit = CH_W'(i);
          nextAny = 1'b1;
        end
      end
    end
  end

  assign slotMore = (CW'(curSlot) + CW'(1)) < clCnt[curChan];

  always_comb begin
    nState   = state;
    nChan    = curChan;
    nSlot    = curSlot;
    dpc.load = 1'b0;
    dpc.kind = W_ID;
    unique case (state)
      S_IDLE: if (readStart) begin
        if (anyHit || alwaysSendId) begin
          nState   = S_ID;
          dpc.load = 1'b1;
          dpc.kind = W_ID;
        end else begin
          nState = S_TOK;
        end
      end
      S_ID: if (wordEnd) begin
        if (anyHit) begin
          nState   = S_GEN;
          nChan    = firstHit;
          dpc.load = 1'b1;
          dpc.kind = W_GEN;
        end else begin
          nState = S_TOK;
        end
      end
      S_GEN: if (wordEnd) begin
        dpc.load = 1'b1;
        if (nextAny) begin
          nChan    = nextHit;
          dpc.kind = W_GEN;
        end else begin
          nState   = S_EVT;
          nChan    = firstHit;
          nSlot    = '0;
          dpc.kind = W_EVT;
        end
      end
      S_EVT: if (wordEnd) begin
        if (slotMore) begin
          nSlot    = curSlot + SLOT_W'(1);
          dpc.load = 1'b1;
          dpc.kind = W_EVT;
        end else if (nextAny) begin
          nChan    = nextHit;
          nSlot    = '0;
          dpc.load = 1'b1;
          dpc.kind = W_EVT;
        end else begin
          nState = S_TOK;
        end
      end
      S_TOK:   nState = S_IDLE;
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curChan <= '0;
      curSlot <= '0;
    end else begin
      state   <= nState;
      curChan <= nChan;
      curSlot <= nSlot;
    end
  end

  assign ldChan   = nChan;
  assign ldSlot   = nSlot;
  assign ldCnt    = clCnt[nChan];
  assign tokenOut = (state == S_TOK);

  // R4: the slot being sent never reaches the channel's clamped count
  a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EVT) |-> (CW'(curSlot) < clCnt[curChan]));

  // R7: an empty chip with the option clear hands the token on next cycle
  a_r7_empty_token: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && readStart && !anyHit && !alwaysSendId) |=> tokenOut);

  // R9: token pulse lasts one cycle
  a_r9_token_single: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |=> !tokenOut);
endmodule

// File: rtl/rdo_dp.sv
module rdo_dp
  import rdo_pkg::*;
#(
  parameter int CH_W = $clog2(NUM_CH),
  parameter int CW   = CNT_W,
  parameter int IDW  = ID_W,
  parameter int EW   = EVT_W,
  parameter int WW   = WORD_W,
  localparam int BIT_W   = $clog2(WW),
  localparam int ID_PAD  = WW - 2 - IDW - 1,
  localparam int GEN_PAD = WW - 2 - CH_W - CW - 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtrl_t         dpc,
  input  logic [IDW-1:0]  chipId,
  input  logic [CH_W-1:0] ldChan,
  input  logic [CW-1:0]   ldCnt,
  input  logic [EW-1:0]   memData,
  output logic            serOut,
  output logic            serValid,
  output logic            wordEnd
);
  logic [WW-1:0]    shReg, rawWord, newWord;
  logic [BIT_W-1:0] bitCnt;
  logic             active;

  always_comb begin
    unique case (dpc.kind)
      W_GEN:   rawWord = {2'b10, ldChan, ldCnt, {GEN_PAD{1'b0}}, 1'b0};
      W_EVT:   rawWord = {1'b0, memData, 1'b0};
      default: rawWord = {2'b11, {ID_PAD{1'b0}}, chipId, 1'b0};
    endcase
  end

  assign newWord = addParity(rawWord);
  assign wordEnd = active && (bitCnt == BIT_W'(WW - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
      active <= 1'b0;
    end else if (dpc.load) begin
      shReg  <= newWord;
      bitCnt <= '0;
      active <= 1'b1;
    end else if (active) begin
      shReg  <= {shReg[WW-2:0], 1'b0};
      bitCnt <= bitCnt + BIT_W'(1);
      if (wordEnd) active <= 1'b0;
    end
  end

  assign serOut   = shReg[WW-1];
  assign serValid = active;

  // R2: no hole inside a word
  a_r2_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (serValid && !wordEnd) |=> serValid);

  // R5: every freshly loaded word has even parity
  a_r5_even_parity: assert property (@(posedge clk) disable iff (!rstN)
    dpc.load |=> ((^shReg) == 1'b0));
endmodule

// File: rtl/rdo_serializer.sv
module rdo_serializer
  import rdo_pkg::*;
#(
  parameter int NCH  = NUM_CH,
  parameter int NEVT = MAX_EVT,
  parameter int CW   = CNT_W,
  parameter int IDW  = ID_W,
  parameter int EW   = EVT_W,
  localparam int CH_W   = $clog2(NCH),
  localparam int SLOT_W = $clog2(NEVT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readStart,
  input  logic [IDW-1:0]    chipId,
  input  logic              alwaysSendId,
  input  logic [NCH*CW-1:0] evtCount,
  output logic [CH_W-1:0]   memChan,
  output logic [SLOT_W-1:0] memSlot,
  input  logic [EW-1:0]     memData,
  output logic              serOut,
  output logic              serValid,
  output logic              tokenOut
);
  dpCtrl_t         dpc;
  logic            wordEnd;
  logic [CH_W-1:0] ldChan;
  logic [CW-1:0]   ldCnt;

  rdo_ctrl #(.NCH(NCH), .NEVT(NEVT), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .readStart(readStart), .alwaysSendId(alwaysSendId),
    .evtCount(evtCount), .wordEnd(wordEnd), .dpc(dpc), .ldChan(ldChan),
    .ldSlot(memSlot), .ldCnt(ldCnt), .tokenOut(tokenOut)
  );

  rdo_dp #(.CH_W(CH_W), .CW(CW), .IDW(IDW), .EW(EW), .WW(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpc(dpc), .chipId(chipId), .ldChan(ldChan),
    .ldCnt(ldCnt), .memData(memData), .serOut(serOut), .serValid(serValid),
    .wordEnd(wordEnd)
  );

  assign memChan = ldChan;

  // R9: the token never overlaps a serial bit
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |-> !serValid);
endmodule

// File: tb/tb_rdo_serializer.sv
module tb_rdo_serializer;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         readStart = 1'b0;
  logic [6:0]   chipId = 7'h5A;
  logic         alwaysSendId = 1'b0;
  logic [255:0] evtCount;
  logic [5:0]   memChan;
  logic [2:0]   memSlot;
  logic [13:0]  memData;
  logic         serOut, serValid, tokenOut;

  logic [3:0]  cntArr [64];
  logic [13:0] memArr [64][8];

  always #10 clk = ~clk;

  always_comb
    for (int c = 0; c < 64; c++) evtCount[c*4 +: 4] = cntArr[c];
  assign memData = memArr[memChan][memSlot];

  rdo_serializer dut (
    .clk(clk), .rstN(rstN), .readStart(readStart), .chipId(chipId),
    .alwaysSendId(alwaysSendId), .evtCount(evtCount), .memChan(memChan),
    .memSlot(memSlot), .memData(memData), .serOut(serOut),
    .serValid(serValid), .tokenOut(tokenOut)
  );

  int checks = 0, errors = 0;
  int cyc = 0, firstValid = -1, lastValid = -1, tokCyc = -1, tokCount = 0;
  int bitsSeen = 0, nb = 0;
  logic [15:0] shIn;
  logic [15:0] expQ [$];
  string       tagQ [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] par(input logic [15:0] w);
    return {w[15:1], ^w[15:1]};
  endfunction

  // monitor: collects serial words and compares them with the scoreboard
  always @(negedge clk) begin
    cyc++;
    if (serValid) begin
      if (firstValid < 0) firstValid = cyc;
      lastValid = cyc;
      bitsSeen++;
      shIn = {shIn[14:0], serOut};
      nb++;
      if (nb == 16) begin
        nb = 0;
        check((^shIn) == 1'b0, "R5 parity", int'(shIn), int'(par(shIn)));
        if (expQ.size() == 0) begin
          check(1'b0, "R2 extra word", int'(shIn), 0);
        end else begin
          logic [15:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(shIn == e, t, int'(shIn), int'(e));
        end
      end
    end
    if (tokenOut) begin
      tokCount++;
      tokCyc = cyc;
    end
  end

  // driver: builds the expected words for the current store contents
  task automatic buildExpected();
    bit any = 0;
    for (int c = 0; c < 64; c++) if (cntArr[c] != 0) any = 1;
    if (!any && !alwaysSendId) return;
    expQ.push_back(par({2'b11, 6'b0, chipId, 1'b0}));       // R1
    tagQ.push_back(any ? "R1 id word" : "R8 id-only word");
    for (int c = 63; c >= 0; c--) begin                    // R3, R6
      int n = (cntArr[c] > 8) ? 8 : int'(cntArr[c]);
      if (n > 0) begin
        expQ.push_back(par({2'b10, 6'(c), 4'(n), 3'b0, 1'b0}));
        tagQ.push_back(cntArr[c] > 8 ? "R6 clamped summary" : "R3 summary word");
      end
    end
    for (int c = 63; c >= 0; c--) begin                    // R4, R6
      int n = (cntArr[c] > 8) ? 8 : int'(cntArr[c]);
      for (int s = 0; s < n; s++) begin
        expQ.push_back(par({1'b0, memArr[c][s], 1'b0}));
        tagQ.push_back("R4 event word");
      end
    end
  endtask

  task automatic pulseStart();
    readStart = 1'b1;
    @(negedge clk); #1;
    readStart = 1'b0;
  endtask

  // one readout; extraOff > 1 re-pulses readStart that many cycles after start (R10)
  task automatic runReadout(input string name, input int extraOff);
    int bits, startCyc, waitN;
    expQ.delete();
    tagQ.delete();
    buildExpected();
    bits = expQ.size() * 16;
    firstValid = -1; lastValid = -1; tokCyc = -1; tokCount = 0;
    bitsSeen = 0; nb = 0;
    @(negedge clk); #1;
    startCyc = cyc;
    fork
      begin
        pulseStart();
        if (extraOff > 1) begin
          repeat (extraOff - 1) @(negedge clk);
          #1;
          pulseStart();
        end
      end
      begin
        waitN = 0;
        while (tokCount == 0 && waitN < 4000) begin
          @(negedge clk);
          waitN++;
        end
        #2;
      end
    join
    repeat (20) @(negedge clk);
    #1;
    check(expQ.size() == 0, {name, " R2 all words sent"}, expQ.size(), 0);
    check(tokCount == 1, {name, " R9/R10 single token"}, tokCount, 1);
    check(bitsSeen == bits, {name, " R10 bit total"}, bitsSeen, bits);
    if (bits == 0) begin
      check(tokCyc == startCyc + 1, {name, " R7 immediate token"}, tokCyc, startCyc + 1);
    end else begin
      check(firstValid == startCyc + 1, {name, " R1 first bit timing"}, firstValid, startCyc + 1);
      check(lastValid - firstValid + 1 == bits, {name, " R2 gap-free"},
            lastValid - firstValid + 1, bits);
      check(tokCyc == lastValid + 1, {name, " R9 token after last bit"}, tokCyc, lastValid + 1);
    end
  endtask

  task automatic clearStore();
    for (int c = 0; c < 64; c++) cntArr[c] = 4'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 64; c++)
      for (int s = 0; s < 8; s++)
        memArr[c][s] = 14'((c * 397 + s * 1103 + 17) ^ (c << 7));
    clearStore();
    repeat (4) @(negedge clk);
    #1;
    check(serValid == 1'b0 && tokenOut == 1'b0, "R9 reset idle",
          {serValid, tokenOut}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    alwaysSendId = 1'b0;
    runReadout("empty-silent", 0);                         // R7

    alwaysSendId = 1'b1;
    runReadout("empty-id", 0);                             // R8

    alwaysSendId = 1'b0;
    cntArr[20] = 4'd2;
    cntArr[43] = 4'd1;
    runReadout("two-channels", 0);                         // R3 R4

    clearStore();
    cntArr[63] = 4'd8;
    cntArr[5]  = 4'd3;
    cntArr[0]  = 4'd12;
    chipId = 7'h13;
    runReadout("edges-clamp", 40);                         // R6, R10 mid-stream

    runReadout("restart-last-bit", (1 + 3 + 19) * 16);     // R10 on final bit
    runReadout("restart-token", (1 + 3 + 19) * 16 + 1);   // R10 on token cycle

    clearStore();
    for (int c = 0; c < 64; c++) cntArr[c] = 4'd1;
    alwaysSendId = 1'b1;
    runReadout("all-channels", 0);                         // R3 R4 full scan

    clearStore();
    cntArr[7] = 4'd15;
    chipId = 7'h7F;
    runReadout("single-max", 0);                           // R6, R5

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule